// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a processor's write to the software-interrupt trigger register into a request that marks one interrupt ID pending on a computed set of CPUs. Each write carries a 10-bit interrupt ID, an explicit CPU list and a 2-bit target selector. The block also receives the index of the CPU that performed the write. From these it forms a per-CPU mask and sends it, with the ID, to the pending storage. The pending storage then sets its bits and runs arbitration again.

Only a full-word write to the register's fixed offset is accepted. The request leaves the block as a single-cycle pulse, one clock after the write. The number of implemented CPUs is a parameter of 1 to 8. The mask output is always 8 bits wide, and its lanes above the implemented count stay at zero.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, and in every cycle without a request pulse, `set_valid`, `set_mask` and `set_id` are all zero.
- R2: A write is accepted only when `wr_en` is high, `wr_addr` equals the parameter `TRIG_OFFSET`, and all four bits of `wr_be` are set. Any other write produces no pulse.
- R3: `set_id` carries bits 9:0 of the accepted write data. Data bits 15:10 and 31:26 have no effect on any output.
- R4: Selector value 0 (data bits 25:24 = 2'b00) targets the CPUs whose bits are set in data bits 23:16, with bit 16 for CPU 0. List bits for CPUs that are not implemented are dropped.
- R5: Selector value 1 targets every implemented CPU except the writer.
- R6: Selector value 2 targets the writer only.
- R7: Selector value 3 is reserved and targets every implemented CPU.
- R8: For an accepted write sampled at clock edge N, the request appears after edge N and lasts exactly one cycle. Accepted writes on consecutive cycles each produce their own pulse.
- R9: Bits of `set_mask` at positions NCPU and above are always zero.
- R10: An accepted write whose computed mask is empty produces no pulse.
- R11: A writer index of NCPU or more counts as no implemented writer. Selector 1 then targets all implemented CPUs, and selector 2 targets none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| wr_cpu | input | 3 | Index of the writing CPU |
| set_valid | output | 1 | Pending-set request pulse |
| set_mask | output | 8 | CPUs on which the ID becomes pending |
| set_id | output | 10 | Interrupt ID to mark pending |

## Verification
The assertions check the following on every cycle:
- A pulse always traces back to a qualified write one cycle earlier, and a write that fails qualification is never followed by a pulse.
- The ID matches the data of that earlier write.
- A pulse never carries an empty mask.
- Idle outputs are zero and lanes above the implemented CPUs stay clear.
- A writer-only request names exactly one CPU.

How each selector value combines the list with the writer index is shown only by the bench's scenarios. These include the masking of list bits for absent CPUs, out-of-range writer indices and back-to-back writes, together with the pending array the bench builds from the request stream.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int MAX_CPU  = 8;
    localparam int ID_W     = 10;
    localparam int IDX_W    = 3;
    localparam int LIST_LSB = 16;
    localparam int SEL_LSB  = 24;

    typedef enum logic [1:0] {
        TGT_LIST   = 2'd0,
        TGT_OTHERS = 2'd1,
        TGT_SELF   = 2'd2,
        TGT_ALL    = 2'd3
    } tgt_sel_e;

    typedef struct packed {
        logic               vld;
        logic [MAX_CPU-1:0] mask;
        logic [ID_W-1:0]    id;
    } sgi_req_t;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode #(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] TRIG_OFFSET = 'hF00
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    output logic              hit
);
    // Only a full-word store to the trigger offset counts.
    always_comb begin
        hit = wr_en && (wr_addr == TRIG_OFFSET) && (wr_be == 4'hF);
    end
endmodule

// File: rtl/sgi_target.sv
module sgi_target
    import sgi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  tgt_sel_e           sel,
    input  logic [MAX_CPU-1:0] list,
    input  logic [IDX_W-1:0]   writer,
    output logic [MAX_CPU-1:0] mask
);
    // One lane per possible CPU; absent lanes are tied off.
    for (genvar g = 0; g < MAX_CPU; g++) begin : g_lane
        if (g < NCPU) begin : g_impl
            logic is_writer;
            always_comb begin
                is_writer = (writer == IDX_W'(g));
                unique case (sel)
                    TGT_LIST:   mask[g] = list[g];
                    TGT_OTHERS: mask[g] = !is_writer;
                    TGT_SELF:   mask[g] = is_writer;
                    default:    mask[g] = 1'b1;
                endcase
            end
        end else begin : g_absent
            assign mask[g] = 1'b0;
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int                NCPU        = 4,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] TRIG_OFFSET = 'hF00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [3:0]         wr_be,
    input  logic [31:0]        wr_data,
    input  logic [IDX_W-1:0]   wr_cpu,
    output logic               set_valid,
    output logic [MAX_CPU-1:0] set_mask,
    output logic [ID_W-1:0]    set_id
);
    logic               hit;
    logic [MAX_CPU-1:0] tgt_mask;
    tgt_sel_e           sel;
    sgi_req_t           req_d, req_q;
    logic               unused_data;

    assign sel         = tgt_sel_e'(wr_data[SEL_LSB +: 2]);
    assign unused_data = ^{wr_data[31:26], wr_data[15:10]};

    sgi_decode #(
        .ADDR_W      (ADDR_W),
        .TRIG_OFFSET (TRIG_OFFSET)
    ) decode_i (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .hit     (hit)
    );

    sgi_target #(
        .NCPU (NCPU)
    ) target_i (
        .sel    (sel),
        .list   (wr_data[LIST_LSB +: MAX_CPU]),
        .writer (wr_cpu),
        .mask   (tgt_mask)
    );

    always_comb begin
        req_d = '0;
        if (hit && (tgt_mask != '0)) begin
            req_d.vld  = 1'b1;
            req_d.mask = tgt_mask;
            req_d.id   = wr_data[ID_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign set_valid = req_q.vld;
    assign set_mask  = req_q.mask;
    assign set_id    = req_q.id;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int                NCPU        = 4,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] TRIG_OFFSET = 'hF00
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [3:0]         wr_be,
    input logic [31:0]        wr_data,
    input logic [IDX_W-1:0]   wr_cpu,
    input logic               set_valid,
    input logic [MAX_CPU-1:0] set_mask,
    input logic [ID_W-1:0]    set_id
);
    localparam logic [MAX_CPU-1:0] IMPL = MAX_CPU'((9'd1 << NCPU) - 9'd1);

    logic qual;
    assign qual = wr_en && (wr_addr == TRIG_OFFSET) && (wr_be == 4'hF);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !set_valid |-> (set_mask == '0 && set_id == '0));

    p_unqualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> !set_valid);

    p_id_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (!set_valid || set_id == $past(wr_data[ID_W-1:0])));

    p_self_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && wr_data[25:24] == 2'd2) |=> (!set_valid || $countones(set_mask) == 1));

    p_pulse_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> $past(qual));

    p_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask & ~IMPL) == '0);

    p_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> set_mask != '0);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
    .NCPU        (NCPU),
    .ADDR_W      (ADDR_W),
    .TRIG_OFFSET (TRIG_OFFSET)
) chk_i (.*);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb_top;
    localparam int          NCPU = 4;
    localparam int          AW   = 12;
    localparam logic [11:0] OFS  = 12'hF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_cpu = '0;
    logic        set_valid;
    logic [7:0]  set_mask;
    logic [9:0]  set_id;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [1023:0] pend_ref [8];
    logic [1023:0] pend_dut [8];

    always #4 clk = ~clk;

    sgi_dispatch #(.NCPU(NCPU), .ADDR_W(AW), .TRIG_OFFSET(OFS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .wr_cpu(wr_cpu),
        .set_valid(set_valid), .set_mask(set_mask), .set_id(set_id));

    // Pending array fed from the design's requests.
    always @(posedge clk) begin
        if (rst_n && set_valid) begin
            for (int c = 0; c < 8; c++)
                if (set_mask[c]) pend_dut[c][set_id] = 1'b1;
        end
    end

    function automatic logic [7:0] exp_mask(input logic [31:0] d, input logic [2:0] w);
        logic [7:0] all;
        logic [7:0] self;
        all  = 8'((9'd1 << NCPU) - 9'd1);
        self = (int'(w) < NCPU) ? 8'(1 << w) : 8'h00;
        case (d[25:24])
            2'd0:    return d[23:16] & all;
            2'd1:    return all & ~self;
            2'd2:    return self;
            default: return all;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, then check the registered result.
    task automatic step(input string req, input logic en, input logic [11:0] a,
                        input logic [3:0] be, input logic [31:0] d, input logic [2:0] w);
        logic       acc;
        logic [7:0] m;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_be = be; wr_data = d; wr_cpu = w;
        acc = en && (a == OFS) && (be == 4'hF);
        m   = acc ? exp_mask(d, w) : 8'h00;
        if (m != 0)
            for (int c = 0; c < 8; c++) if (m[c]) pend_ref[c][d[9:0]] = 1'b1;
        @(posedge clk);
        #1;
        check(req, {22'd0, set_valid, set_id}, {22'd0, (m != 0), (m != 0) ? d[9:0] : 10'd0});
        check(req, {24'd0, set_mask}, {24'd0, m});
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin pend_ref[c] = '0; pend_dut[c] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1", {21'd0, set_valid, set_id}, 32'd0);
        check("R1", {24'd0, set_mask}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        step("R4", 1, OFS, 4'hF, 32'h0005_0123, 3'd0);
        check("R8", {31'd0, set_valid}, 32'd1);
        @(negedge clk) wr_en = 1'b0;
        @(posedge clk); #1;
        check("R8", {31'd0, set_valid}, 32'd0);
        step("R4", 1, OFS, 4'hF, 32'h00F2_0044, 3'd1);
        step("R10", 1, OFS, 4'hF, 32'h00F0_0045, 3'd1);
        step("R10", 1, OFS, 4'hF, 32'h0000_0046, 3'd1);
        step("R5", 1, OFS, 4'hF, 32'h0100_0200, 3'd2);
        step("R6", 1, OFS, 4'hF, 32'h0200_0201, 3'd3);
        step("R7", 1, OFS, 4'hF, 32'h0300_03FF, 3'd0);
        step("R11", 1, OFS, 4'hF, 32'h0100_0010, 3'd5);
        step("R11", 1, OFS, 4'hF, 32'h0200_0011, 3'd6);
        step("R2", 1, OFS, 4'h7, 32'h0300_0012, 3'd0);
        step("R2", 1, OFS + 12'd4, 4'hF, 32'h0300_0013, 3'd0);
        step("R2", 0, OFS, 4'hF, 32'h0300_0014, 3'd0);
        step("R3", 1, OFS, 4'hF, 32'hFC02_FC15, 3'd0);
        step("R8", 1, OFS, 4'hF, 32'h0300_0016, 3'd0);
        step("R8", 1, OFS, 4'hF, 32'h0300_0017, 3'd1);
        step("R9", 1, OFS, 4'hF, 32'h03FF_FFFF, 3'd7);

        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            logic        en;
            logic [11:0] a;
            logic [3:0]  be;
            en = ($urandom % 8) != 0;
            a  = (($urandom % 6) != 0) ? OFS : 12'($urandom);
            be = (($urandom % 6) != 0) ? 4'hF : 4'($urandom);
            step("R4", en, a, be, $urandom, 3'($urandom));
            check("R9", {24'd0, set_mask & 8'hF0}, 32'd0);
        end
        @(negedge clk) wr_en = 1'b0;
        @(posedge clk); #1;
        for (int c = 0; c < 8; c++)
            check("R8", {31'd0, pend_dut[c] == pend_ref[c]}, 32'd1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule